// File: doc/BRIEF.md
# Bridge Address Window Mask Decoder

This block sits beside a host-to-PCI bridge. It holds the bridge's address-mask register and answers host addresses against the windows that the mask opens. The mask has two kinds of window. Its low sixteen bits each open one 16 MB slice of the top 256 MB of the address map. Its next fifteen bits each open one 256 MB slice of the space below that. For any host address, the block raises a hit and a one-hot region vector naming the single enabled window that contains the address. It also flags whether the address falls in the bridge's own 16 MB control window or in the 16 MB pass-through window just above it.

Software reaches the mask through a word-wide configuration port. Values cross that port byte-reversed relative to the stored value. The same port returns the fixed identification words of the standard configuration header. The header is read-only: writes to it are dropped. Offsets at or above 64, other than the mask, read as zero and ignore writes. A 2-bit strap input selects which 32 MB slot of the top 256 MB the bridge owns. On reset, the mask opens exactly the two fine windows of that slot.

Top module: `bwin_mask_decoder`

## Requirements
- R1: After a synchronous reset, the stored mask equals 3 shifted left by twice `bridge_idx`. It enables fine regions 2*idx and 2*idx+1 and nothing else.
- R2: For an address whose top nibble is 0xF, fine region k = address bits [27:24] matches when mask bit k is set. Region vector bit k then marks it and `hit` is high.
- R3: For an address whose top nibble p is 0 to 14, coarse region p matches when mask bit 16+p is set. Region vector bit 16+p then marks it and `hit` is high.
- R4: When the mask bit of the region that contains the address is clear, `hit` is low and the region vector is zero. Mask bit 31 opens no region.
- R5: The region vector has at most one bit set. `hit` is high exactly when one bit is set.
- R6: A configuration write at the mask offset stores the write data byte-reversed: data byte 0 becomes mask bits [31:24] and data byte 3 becomes mask bits [7:0]. The new value is in effect from the next clock.
- R7: A configuration read at the mask offset returns the stored mask byte-reversed, combinationally from the offset.
- R8: Header reads return fixed values by word offset:
  - 0x00 returns device id 0x0001 in bits [31:16] and the vendor id parameter in bits [15:0].
  - 0x04 returns 0x00000016 (command).
  - 0x08 returns 0x06000003 (class and revision).
  - 0x0C returns 0x00000008 (cache line size).
  - Every other offset below 64 returns zero.
- R9: Writes to offsets below 64 change neither the header read values nor the mask.
- R10: Offsets of 64 and above, other than the mask offset (default 0x48), read as zero, and writes to them change nothing.
- R11: `ctrl_hit` is high for addresses in [0xF0000000 + idx*0x02000000, +0x01000000). `thru_hit` is high for the 16 MB that follows. The two are never high together, and neither depends on the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_idx | input | 2 | Static strap selecting the bridge's 32 MB slot |
| cfg_addr | input | 8 | Configuration byte offset (bits [1:0] ignored) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| host_addr | input | 32 | Host address to decode |
| hit | output | 1 | Address lies in an enabled window |
| region_oh | output | 31 | One-hot matching region (bits 0-15 fine, 16-30 coarse) |
| ctrl_hit | output | 1 | Address lies in the bridge control window |
| thru_hit | output | 1 | Address lies in the pass-through window |

## Verification
The assertions check four properties on every cycle:
- the reset value of the mask against the strap;
- the byte-reversed capture on a mask write, and that the mask holds on every other cycle;
- that the region vector is one-hot or zero, with no region marked unless its mask bit is set;
- that fine regions are reported only in the top 256 MB, and that the control and pass-through flags stay exclusive.

Only the bench scenarios can show the rest. These are the exact region index chosen for a given address, the header constants and the zero reads at unused offsets, the byte order seen on readback, and the change of slot and reset mask across different strap values.

// File: rtl/bwin_pkg.sv
`timescale 1ns/1ps
package bwin_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int FINE_N   = 16;
    localparam int COARSE_N = 15;
    localparam int REGION_N = FINE_N + COARSE_N;
    localparam int CFG_AW   = 8;
    localparam int HDR_LIMIT = 64;

    localparam logic [3:0]  FINE_NIBBLE  = 4'hF;
    localparam logic [15:0] DEV_ID_VAL   = 16'h0001;
    localparam logic [15:0] CMD_VAL      = 16'h0016;
    localparam logic [31:0] CLASS_VAL    = 32'h0600_0003;
    localparam logic [7:0]  CLSZ_VAL     = 8'h08;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_IDENT,
        SEL_CMD,
        SEL_CLASS,
        SEL_MISC,
        SEL_MASK,
        SEL_ZERO
    } cfg_sel_e;

    typedef struct packed {
        logic                hit;
        logic [REGION_N-1:0] oh;
    } win_match_t;

    typedef struct packed {
        logic ctrl;
        logic thru;
    } slot_match_t;

    function automatic word_t bswap32(input word_t v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic word_t reset_mask(input logic [1:0] idx);
        return word_t'(32'd3) << {idx, 1'b0};
    endfunction

endpackage

// File: rtl/bwin_cfg_regs.sv
`timescale 1ns/1ps
module bwin_cfg_regs
    import bwin_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB0,
    parameter logic [7:0]  MASK_OFFS = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bridge_idx,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  word_t             cfg_wdata,
    output word_t             cfg_rdata,
    output word_t             mask_q
);

    localparam int WORD_AW = CFG_AW - 2;
    localparam logic [WORD_AW-1:0] MASK_WORD = MASK_OFFS[CFG_AW-1:2];

    logic [WORD_AW-1:0] word_idx;
    cfg_sel_e           sel;

    assign word_idx = cfg_addr[CFG_AW-1:2];

    always_comb begin
        sel = SEL_ZERO;
        if (word_idx == MASK_WORD) begin
            sel = SEL_MASK;
        end else if (int'(cfg_addr) < HDR_LIMIT) begin
            unique case (word_idx)
                WORD_AW'(0): sel = SEL_IDENT;
                WORD_AW'(1): sel = SEL_CMD;
                WORD_AW'(2): sel = SEL_CLASS;
                WORD_AW'(3): sel = SEL_MISC;
                default:     sel = SEL_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= reset_mask(bridge_idx);
        end else if (cfg_wr && sel == SEL_MASK) begin
            mask_q <= bswap32(cfg_wdata);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_IDENT: cfg_rdata = {DEV_ID_VAL, VENDOR_ID};
            SEL_CMD:   cfg_rdata = {16'h0000, CMD_VAL};
            SEL_CLASS: cfg_rdata = CLASS_VAL;
            SEL_MISC:  cfg_rdata = {24'h000000, CLSZ_VAL};
            SEL_MASK:  cfg_rdata = bswap32(mask_q);
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bwin_region_match.sv
`timescale 1ns/1ps
module bwin_region_match
    import bwin_pkg::*;
(
    input  logic [ADDR_W-1:0] host_addr,
    input  word_t             mask,
    output win_match_t        match
);

    logic [3:0]          top_nib;
    logic [3:0]          fine_sel;
    logic                in_fine;
    logic [REGION_N-1:0] oh;

    assign top_nib  = host_addr[ADDR_W-1 -: 4];
    assign fine_sel = host_addr[ADDR_W-5 -: 4];
    assign in_fine  = (top_nib == FINE_NIBBLE);

    for (genvar i = 0; i < FINE_N; i++) begin : g_fine
        assign oh[i] = in_fine && (fine_sel == 4'(i)) && mask[i];
    end

    for (genvar j = 0; j < COARSE_N; j++) begin : g_coarse
        assign oh[FINE_N + j] = (top_nib == 4'(j)) && mask[FINE_N + j];
    end

    assign match.oh  = oh;
    assign match.hit = |oh;

endmodule

// File: rtl/bwin_slot_window.sv
`timescale 1ns/1ps
module bwin_slot_window
    import bwin_pkg::*;
(
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        bridge_idx,
    output slot_match_t       slot
);

    logic in_slot;

    assign in_slot   = (host_addr[ADDR_W-1 -: 7] == {FINE_NIBBLE, 1'b0, bridge_idx});
    assign slot.ctrl = in_slot && !host_addr[24];
    assign slot.thru = in_slot &&  host_addr[24];

endmodule

// File: rtl/bwin_mask_decoder.sv
`timescale 1ns/1ps
module bwin_mask_decoder
    import bwin_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB0,
    parameter logic [7:0]  MASK_OFFS = 8'h48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          bridge_idx,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic                cfg_wr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]   host_addr,
    output logic                hit,
    output logic [REGION_N-1:0] region_oh,
    output logic                ctrl_hit,
    output logic                thru_hit
);

    word_t       mask_q;
    win_match_t  match;
    slot_match_t slot;

    bwin_cfg_regs #(
        .VENDOR_ID (VENDOR_ID),
        .MASK_OFFS (MASK_OFFS)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .bridge_idx (bridge_idx),
        .cfg_addr   (cfg_addr),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .mask_q     (mask_q)
    );

    bwin_region_match match_i (
        .host_addr (host_addr),
        .mask      (mask_q),
        .match     (match)
    );

    bwin_slot_window slot_i (
        .host_addr  (host_addr),
        .bridge_idx (bridge_idx),
        .slot       (slot)
    );

    assign hit       = match.hit;
    assign region_oh = match.oh;
    assign ctrl_hit  = slot.ctrl;
    assign thru_hit  = slot.thru;

endmodule

// File: rtl/bwin_checker.sv
`timescale 1ns/1ps
module bwin_checker
    import bwin_pkg::*;
#(
    parameter logic [7:0] MASK_OFFS = 8'h48
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          bridge_idx,
    input logic [CFG_AW-1:0]   cfg_addr,
    input logic                cfg_wr,
    input logic [DATA_W-1:0]   cfg_wdata,
    input logic [ADDR_W-1:0]   host_addr,
    input logic                hit,
    input logic [REGION_N-1:0] region_oh,
    input logic                ctrl_hit,
    input logic                thru_hit,
    input logic [DATA_W-1:0]   mask_q
);

    logic mask_wr;
    assign mask_wr = cfg_wr && (cfg_addr[CFG_AW-1:2] == MASK_OFFS[CFG_AW-1:2]);

    assert_reset_mask_R1: assert property (@(posedge clk)
        rst |=> (mask_q == reset_mask($past(bridge_idx))));

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q == bswap32($past(cfg_wdata))));

    // R9 and R10: only a mask write may change the mask
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));

    assert_oh_single_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_oh) && (hit == ($countones(region_oh) == 1)));

    assert_enabled_only_R4: assert property (@(posedge clk) disable iff (rst)
        (region_oh & ~mask_q[REGION_N-1:0]) == '0);

    assert_fine_span_R2: assert property (@(posedge clk) disable iff (rst)
        (region_oh[FINE_N-1:0] != '0) |-> (host_addr[ADDR_W-1 -: 4] == FINE_NIBBLE));

    assert_win_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_hit && thru_hit));

endmodule

bind bwin_mask_decoder bwin_checker #(.MASK_OFFS(MASK_OFFS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bridge_idx (bridge_idx),
    .cfg_addr   (cfg_addr),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .host_addr  (host_addr),
    .hit        (hit),
    .region_oh  (region_oh),
    .ctrl_hit   (ctrl_hit),
    .thru_hit   (thru_hit),
    .mask_q     (mask_q)
);

// File: tb/bwin_mask_decoder_tb_top.sv
`timescale 1ns/1ps
module bwin_mask_decoder_tb_top;

    localparam logic [7:0]  MOFS = 8'h48;
    localparam logic [15:0] VEND = 16'h1AB0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bridge_idx = 2'd2;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] host_addr = '0;
    logic        hit;
    logic [30:0] region_oh;
    logic        ctrl_hit;
    logic        thru_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bwin_mask_decoder #(.VENDOR_ID(VEND), .MASK_OFFS(MOFS)) dut_i (
        .clk (clk), .rst (rst), .bridge_idx (bridge_idx),
        .cfg_addr (cfg_addr), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .host_addr (host_addr), .hit (hit),
        .region_oh (region_oh), .ctrl_hit (ctrl_hit), .thru_hit (thru_hit)
    );

    function automatic logic [31:0] swap(input logic [31:0] v);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = v[8*(3-b) +: 8];
        return r;
    endfunction

    // reference model state
    logic [31:0] m_mask;
    always @(posedge clk) begin
        if (rst) m_mask <= 32'd3 << (2 * bridge_idx);
        else if (cfg_wr && cfg_addr == MOFS) m_mask <= swap(cfg_wdata);
    end

    function automatic logic [30:0] m_oh(input logic [31:0] a, input logic [31:0] m);
        longint ua;
        int k;
        logic [30:0] r;
        r = '0;
        ua = longint'(a);
        if (ua >= 64'hF000_0000) begin
            k = int'((ua - 64'hF000_0000) / 64'h0100_0000);
            if (m[k]) r[k] = 1'b1;
        end else begin
            k = int'(ua / 64'h1000_0000);
            if (m[16 + k]) r[16 + k] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] o, input logic [31:0] m);
        if (o == MOFS) return swap(m);
        case (o)
            8'h00:   return {16'h0001, VEND};
            8'h04:   return 32'h0000_0016;
            8'h08:   return 32'h0600_0003;
            8'h0C:   return 32'h0000_0008;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] m_slot(input logic [31:0] a, input logic [1:0] idx);
        longint base;
        longint ua;
        base = 64'hF000_0000 + longint'(idx) * 64'h0200_0000;
        ua = longint'(a);
        return {(ua >= base && ua < base + 64'h0100_0000),
                (ua >= base + 64'h0100_0000 && ua < base + 64'h0200_0000)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk((host_addr >= 32'hF000_0000) ? "R2" : "R3", {1'b0, region_oh}, {1'b0, m_oh(host_addr, m_mask)});
            chk("R5", {31'b0, hit}, {31'b0, |m_oh(host_addr, m_mask)});
            chk("R11", {30'b0, ctrl_hit, thru_hit}, {30'b0, m_slot(host_addr, bridge_idx)});
            chk((cfg_addr == MOFS) ? "R7" : (cfg_addr < 8'd64) ? "R8" : "R10", cfg_rdata, m_rd(cfg_addr, m_mask));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] idx);
        tick();
        rst = 1'b1;
        bridge_idx = idx;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] o, input logic [31:0] d);
        tick();
        cfg_addr = o;
        cfg_wdata = d;
        cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] o, input logic [31:0] exp);
        tick();
        cfg_addr = o;
        @(negedge clk);
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic host_chk(input string tag, input logic [31:0] a, input logic [30:0] exp_oh,
                            input logic exp_ctrl, input logic exp_thru);
        tick();
        host_addr = a;
        @(negedge clk);
        chk(tag, {1'b0, region_oh}, {1'b0, exp_oh});
        chk(tag, {31'b0, hit}, {31'b0, exp_oh != '0});
        chk("R11", {30'b0, ctrl_hit, thru_hit}, {30'b0, exp_ctrl, exp_thru});
    endtask

    initial begin
        do_reset(2'd2);
        // R1: idx 2 opens fine regions 4 and 5
        rd_chk("R1", MOFS, 32'h3000_0000);
        host_chk("R2", 32'hF412_3456, 31'h0000_0010, 1'b1, 1'b0);
        host_chk("R2", 32'hF5FF_FFFF, 31'h0000_0020, 1'b0, 1'b1);
        host_chk("R4", 32'hF600_0000, 31'h0, 1'b0, 1'b0);
        host_chk("R4", 32'h1000_0000, 31'h0, 1'b0, 1'b0);

        // R6: stored mask 0xC0014001 (bits 31,30,16,14,0)
        cfg_write(MOFS, 32'h0140_01C0);
        rd_chk("R7", MOFS, 32'h0140_01C0);
        host_chk("R3", 32'h0000_0010, 31'h0001_0000, 1'b0, 1'b0);
        host_chk("R3", 32'hE800_0000, 31'h4000_0000, 1'b0, 1'b0);
        host_chk("R4", 32'h7000_0000, 31'h0, 1'b0, 1'b0);
        host_chk("R6", 32'hFE00_0000, 31'h0000_4000, 1'b0, 1'b0);
        host_chk("R6", 32'hF000_0000, 31'h0000_0001, 1'b0, 1'b0);
        host_chk("R4", 32'hFF00_0000, 31'h0, 1'b0, 1'b0);
        host_chk("R11", 32'hF400_0000, 31'h0, 1'b1, 1'b0);

        // R8: header constants
        rd_chk("R8", 8'h00, {16'h0001, VEND});
        rd_chk("R8", 8'h04, 32'h0000_0016);
        rd_chk("R8", 8'h08, 32'h0600_0003);
        rd_chk("R8", 8'h0C, 32'h0000_0008);
        rd_chk("R8", 8'h10, 32'h0);
        rd_chk("R8", 8'h3C, 32'h0);

        // R9: header writes are dropped
        cfg_write(8'h04, 32'hFFFF_FFFF);
        cfg_write(8'h0C, 32'h0000_0040);
        cfg_write(8'h00, 32'h1234_5678);
        rd_chk("R9", 8'h04, 32'h0000_0016);
        rd_chk("R9", 8'h0C, 32'h0000_0008);
        rd_chk("R9", 8'h00, {16'h0001, VEND});
        rd_chk("R9", MOFS, 32'h0140_01C0);

        // R10: unimplemented upper offsets
        cfg_write(8'h50, 32'hDEAD_BEEF);
        rd_chk("R10", 8'h50, 32'h0);
        rd_chk("R10", 8'hFC, 32'h0);
        rd_chk("R10", MOFS, 32'h0140_01C0);

        // R6/R7: byte order with distinct bytes, stored 0x78563412
        cfg_write(MOFS, 32'h1234_5678);
        rd_chk("R7", MOFS, 32'h1234_5678);
        host_chk("R6", 32'hF100_0000, 31'h0000_0002, 1'b0, 1'b0);
        host_chk("R6", 32'h1ABC_0000, 31'h0002_0000, 1'b0, 1'b0);

        // R1 with other straps
        do_reset(2'd3);
        rd_chk("R1", MOFS, 32'hC000_0000);
        host_chk("R1", 32'hF700_0000, 31'h0000_0080, 1'b0, 1'b1);
        do_reset(2'd0);
        rd_chk("R1", MOFS, 32'h0300_0000);
        host_chk("R1", 32'hF080_0000, 31'h0000_0001, 1'b1, 1'b0);

        tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule